// File: doc/BRIEF.md
# Divide-by-Three Clock Divider with Even Duty Cycle

This block turns an input clock into an output clock at one third of its frequency. The output is high for exactly half of each output period, which is one and a half input periods. A ratio of three is odd, so rising edges alone cannot produce an even duty cycle. The block therefore uses the falling edge of the input clock as well.

The design has three storage bits. Two of them update on the rising edge and form a three-state sequencer built around a single NOR feedback term. The third updates on the falling edge and holds a copy of the sequencer's low bit that lags by half an input period. The output is the OR of the low bit and its delayed copy. At any clock edge only one of these two terms changes, so the output cannot glitch.

The circuit does not need a reset. A synchronous clear input is still provided. It puts the sequencer on a parameterised code (`CLEAR_CODE`, default 00) and the delayed bit on 0, so that a run can start from a known state. The sequencer state is brought out on a port so that it can be observed.

Top module: `div3_even_duty`

## Requirements
- R1: Once running, consecutive rising edges of `clk_o` are exactly three `clk_i` periods apart.
- R2: Each high phase of `clk_o` lasts exactly one and a half `clk_i` periods.
- R3: With `clr_i` low, each rising edge of `clk_i` moves `state_o` (bit 1 = high sequencer bit, bit 0 = low sequencer bit) through the order 00, 01, 10 and back to 00.
- R4: The unused code 11 is not a trap. With `clr_i` low, it moves to 10 at the next rising edge.
- R5: `clk_o` rises only at a rising edge of `clk_i` and falls only at a falling edge of `clk_i`.
- R6: If `clr_i` is high at a rising edge, `state_o` becomes `CLEAR_CODE`. If `clr_i` is high at a falling edge, the delayed bit becomes 0. With the default code 00, `clk_o` is low while the clear is held.
- R7: Half a period after a rising edge, `clk_o` is high when the new state is 01, or when the new state is 10 after 01. Half a period after a falling edge, `clk_o` equals `state_o` bit 0.
- R8: From each of the four starting codes, the output follows the steady divide-by-three pattern from the first rising edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock; both edges are used |
| clr_i | input | 1 | Synchronous clear to `CLEAR_CODE` and delayed bit 0 |
| clk_o | output | 1 | Divided clock, one third of the input frequency, even duty cycle |
| state_o | output | 2 | Sequencer state {high bit, low bit} |

## Verification
The bench starts one copy of the divider from each of the four sequencer codes, including the unused code 11. A sequencer that could lock up would stay on 11 and hold the output high. A wrong NOR feedback would show up as an output period of two or four input periods. A delayed bit sampled on the wrong edge would make the high time one or two input periods instead of one and a half. An output built from terms that change together would show an edge that is not aligned with the matching input edge. The bench also applies the clear both at start-up and in the middle of a run.

// File: rtl/div3_even_duty.sv
module div3_even_duty #(
  parameter logic [1:0] CLEAR_CODE = 2'b00
) (
  input  logic       clk_i,
  input  logic       clr_i,
  output logic       clk_o,
  output logic [1:0] state_o
);
  logic lo_q, hi_q, lag_q;

  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      lo_q <= CLEAR_CODE[0];
      hi_q <= CLEAR_CODE[1];
    end else begin
      lo_q <= ~(lo_q | hi_q);
      hi_q <= lo_q;
    end
  end

  always_ff @(negedge clk_i) begin
    if (clr_i) lag_q <= 1'b0;
    else       lag_q <= lo_q;
  end

  assign clk_o   = lo_q | lag_q;
  assign state_o = {hi_q, lo_q};

  p_seq_a_r3: assert property (@(posedge clk_i) disable iff (clr_i)
    (state_o == 2'b00) |=> (state_o == 2'b01));
  p_seq_b_r3: assert property (@(posedge clk_i) disable iff (clr_i)
    (state_o == 2'b01) |=> (state_o == 2'b10));
  p_seq_c_r3: assert property (@(posedge clk_i) disable iff (clr_i)
    (state_o == 2'b10) |=> (state_o == 2'b00));
  p_nolock_r4: assert property (@(posedge clk_i) disable iff (clr_i)
    (state_o == 2'b11) |=> (state_o == 2'b10));
  p_clear_r6: assert property (@(posedge clk_i)
    clr_i |=> (state_o == CLEAR_CODE));
  p_lag_r7: assert property (@(negedge clk_i) disable iff (clr_i)
    lag_q |-> (state_o == 2'b10));
  p_low_r7: assert property (@(posedge clk_i) disable iff (clr_i)
    (state_o == 2'b00) |-> !clk_o);
endmodule

// File: tb/div3_even_duty_test.sv
`timescale 1ns/100ps
module div3_even_duty_test;
  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic [3:0] clk_o_v;
  logic [1:0] st_v [4];
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  for (genvar g = 0; g < 4; g++) begin : g_dut
    logic [1:0] st;
    div3_even_duty #(.CLEAR_CODE(g)) uut (
      .clk_i(clk), .clr_i(clr), .clk_o(clk_o_v[g]), .state_o(st));
    assign st_v[g] = st;

    always @(posedge clk_o_v[g]) if (!clr) begin
      tests++;
      if (clk !== 1'b1) begin
        fails++;
        $display("FAIL R5 inst %0d: rise with clk_i=%b expected 1", g, clk);
      end
    end
    always @(negedge clk_o_v[g]) if (!clr) begin
      tests++;
      if (clk !== 1'b0) begin
        fails++;
        $display("FAIL R5 inst %0d: fall with clk_i=%b expected 0", g, clk);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] nxt(input logic [1:0] s);
    return {s[0], ~(s[0] | s[1])};
  endfunction

  // item: {inst[1:0], state[1:0], level after rise, level after fall}
  logic [5:0] sbq [$];

  task automatic drive_run(input int n);
    logic [1:0] p [4];
    for (int g = 0; g < 4; g++) p[g] = 2'(g);
    for (int k = 0; k < n; k++)
      for (int g = 0; g < 4; g++) begin
        logic [1:0] s;
        s = nxt(p[g]);
        sbq.push_back({2'(g), s, s[0] | p[g][0], s[0]});
        p[g] = s;
      end
  endtask

  logic fall_e [4];
  always begin
    @(posedge clk); #1;
    if (sbq.size() >= 4) begin
      for (int i = 0; i < 4; i++) begin
        logic [5:0] it;
        int idx;
        it = sbq.pop_front();
        idx = int'(it[5:4]);
        chk(st_v[idx] == it[3:2],
            (it[3:2] == 2'b10 && idx == 3) ? "R4 state after 11" : "R3/R8 state",
            int'(st_v[idx]), int'(it[3:2]));
        chk(clk_o_v[idx] == it[1], "R7 level after rise", int'(clk_o_v[idx]), int'(it[1]));
        fall_e[idx] = it[0];
      end
      @(negedge clk); #1;
      for (int i = 0; i < 4; i++)
        chk(clk_o_v[i] == fall_e[i], "R7 level after fall", int'(clk_o_v[i]), int'(fall_e[i]));
    end
  end

  logic meas = 1'b0;
  logic have_rise = 1'b0;
  realtime last_rise;
  always @(posedge clk_o_v[0]) if (meas) begin
    if (have_rise)
      chk(($realtime - last_rise) == 12.0, "R1 period ns",
          int'($realtime - last_rise), 12);
    last_rise = $realtime;
    have_rise = 1'b1;
  end
  always @(negedge clk_o_v[0]) if (meas && have_rise)
    chk(($realtime - last_rise) == 6.0, "R2 high time ns",
        int'($realtime - last_rise), 6);

  task automatic clear_and_check;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    for (int g = 0; g < 4; g++)
      chk(st_v[g] == 2'(g), "R6 clear state", int'(st_v[g]), g);
    chk(clk_o_v[0] == 1'b0, "R6 output low in clear", int'(clk_o_v[0]), 0);
  endtask

  task automatic run_pass(input int n);
    @(posedge clk); #0.5;
    clr = 1'b0;
    meas = 1'b1;
    @(negedge clk); #0.5;
    drive_run(n);
    wait (sbq.size() == 0);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    clear_and_check();
    run_pass(12);
    @(posedge clk); #0.5;
    meas = 1'b0;
    have_rise = 1'b0;
    clr = 1'b1;
    clear_and_check();
    run_pass(7);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule